// File: doc/BRIEF.md
# Wear-Adaptive Codeword Length Controller

This block chooses how long the error-correction codeword should be on one NAND flash channel as the medium ages. It watches two signs of wear: a running count of completed erase operations, and the number of bits the decoder corrected in each codeword it reports. When either one passes the programmed limit for the present setting, the controller moves to the next longer codeword. The lengths double from 512 bytes up to 32 KB, seven settings in all, numbered 0 to 6.

The parity overhead stays in the same proportion to the data at every setting. The block therefore reports three numbers for the datapath: the data length, the correction strength in bits, and the parity byte count. Each of them doubles from one setting to the next. A move to a longer codeword is only applied at a codeword boundary, which the datapath marks with an idle input. A one-cycle strobe tells the datapath to reconfigure. The setting never goes back down. It stops at 32 KB, and only a synchronous reset returns it to 512 bytes.

The encoder, the decoder, flash timing and data storage lie outside this block. It only makes the decision and reports the resulting configuration.

Top module: `cwlen_ctrl`

## Requirements
- R1: After reset the level output is 0, the data length is 512, the correction strength is 8, the parity count is 13 and the change strobe is low.
- R2: At level L the data length is 512 shifted left by L, the correction strength is 8 shifted left by L, and the parity count is 13 shifted left by L, so parity and data keep the ratio 13:512.
- R3: The level never decreases between resets, and in any one clock cycle it rises by at most one.
- R4: Each erase_done pulse adds one to a saturating wear count. When that count is at least the cycle threshold of the current level, a step is armed one cycle later. The cycle threshold of level L is bits [20L+19:20L] of cyc_thr.
- R5: A report (err_valid high) arms a step when its err_count is at least the error threshold of the current level shifted left by the level. A report below that value arms nothing. The error threshold of level L is bits [10L+9:10L] of err_thr.
- R6: An armed step is applied only on a clock edge where cw_idle is high. While cw_idle stays low, the step stays armed and the level holds.
- R7: lvl_chg is high for exactly the one cycle in which the new level first appears on the outputs, and it is high at no other time.
- R8: A single applied step raises the level by exactly one, even when the wear count or an error report is past the thresholds of several levels.
- R9: At level 6 the controller ignores every trigger: the level stays at 6 and lvl_chg stays low.
- R10: A synchronous reset (rst_n low) returns the level to 0 and clears the wear count.
- R11: A trigger that arrives on the same edge as an applied step is discarded, because it was judged against the old level. It arms nothing for the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| erase_done | input | 1 | One-cycle pulse per completed erase operation |
| err_valid | input | 1 | Marks a valid per-codeword corrected-error report |
| err_count | input | 10 | Number of bits corrected in the reported codeword |
| cw_idle | input | 1 | High at a codeword boundary, where a step may be applied |
| cyc_thr | input | 120 | Six 20-bit wear-count thresholds, one for each of levels 0 to 5 |
| err_thr | input | 60 | Six 10-bit error thresholds, one for each of levels 0 to 5, in units of one 512-byte codeword |
| level | output | 3 | Current codeword length level, 0 to 6 |
| data_bytes | output | 16 | Data bytes per codeword |
| corr_bits | output | 10 | Correctable bits per codeword |
| parity_bytes | output | 10 | Parity bytes per codeword |
| lvl_chg | output | 1 | One-cycle strobe marking a new level |

## Verification
Two functions can meet on one clock edge. Arming a step from an error report, and applying a step that is already armed, can both happen on the same edge. To provoke this, the bench arms a step while cw_idle is low. Then, in a single cycle, it raises cw_idle and sends a report that passes the old level's threshold and would also pass the new one. The bench expects exactly one step, with lvl_chg high in that cycle. After that the level must stay put through several idle cycles, which shows the coinciding report was not carried forward. The per-level checks of the strobe count and the level value then confirm that the arming and applying paths never double-count.

// File: rtl/cwl_pkg.sv
// Package: shared constants and the level type for the codeword length controller.
// Assumes seven levels; level 6 is the ceiling.
package cwl_pkg;
    localparam int unsigned NUM_LVL = 7;
    localparam int unsigned MAX_LVL = NUM_LVL - 1;
    localparam int unsigned LVL_W   = $clog2(NUM_LVL);
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/cwl_wear_cnt.sv
// Module: saturating counter of completed erase operations.
// Assumes inc is a single-cycle pulse; holds at all-ones instead of wrapping.
module cwl_wear_cnt #(
    parameter int unsigned CYC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CYC_W-1:0] count
);
    // Count erase pulses, clear on reset, stop at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != {CYC_W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cwl_trig.sv
// Module: decides whether the current level should be left.
// Assumes flat threshold buses with the level-0 entry in the lowest bits;
// no trigger is raised at the top level.
module cwl_trig
    import cwl_pkg::*;
#(
    parameter int unsigned CYC_W  = 20,
    parameter int unsigned ERR_W  = 10,
    parameter int unsigned ETHR_W = 10
) (
    input  lvl_t                          level,
    input  logic [CYC_W-1:0]              wear,
    input  logic                          err_valid,
    input  logic [ERR_W-1:0]              err_count,
    input  logic [(NUM_LVL-1)*CYC_W-1:0]  cyc_thr,
    input  logic [(NUM_LVL-1)*ETHR_W-1:0] err_thr,
    output logic                          trig
);
    localparam int unsigned SCL_W = ((ETHR_W > ERR_W) ? ETHR_W : ERR_W) + MAX_LVL;

    logic [CYC_W-1:0]  cyc_a [NUM_LVL-1];
    logic [ETHR_W-1:0] err_a [NUM_LVL-1];

    // Split the flat threshold buses into one entry per level.
    for (genvar g = 0; g < NUM_LVL - 1; g++) begin : g_unpack
        assign cyc_a[g] = cyc_thr[g*CYC_W +: CYC_W];
        assign err_a[g] = err_thr[g*ETHR_W +: ETHR_W];
    end

    logic             at_top;
    logic [2:0]       sel;
    logic [SCL_W-1:0] err_lim;
    logic             cyc_hit;
    logic             err_hit;

    // Compare wear and reported errors against the current level's limits.
    always_comb begin
        at_top  = (32'(level) >= MAX_LVL);
        sel     = at_top ? 3'd0 : 3'(level);
        err_lim = SCL_W'(err_a[sel]) << level;
        cyc_hit = (wear >= cyc_a[sel]);
        err_hit = err_valid && (SCL_W'(err_count) >= err_lim);
        trig    = !at_top && (cyc_hit || err_hit);
    end
endmodule

// File: rtl/cwl_step.sv
// Module: holds the level, arms a pending step and applies it at a boundary.
// Assumes trig is judged against the present level; a trigger on the step
// edge is dropped because it refers to the old level.
module cwl_step
    import cwl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic cw_idle,
    output lvl_t level,
    output logic lvl_chg
);
    logic pend;

    // Arm on a trigger, step by one at an idle boundary, strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= '0;
            pend    <= 1'b0;
            lvl_chg <= 1'b0;
        end else begin
            lvl_chg <= 1'b0;
            if (pend && cw_idle && (32'(level) < MAX_LVL)) begin
                level   <= level + 1'b1;
                pend    <= 1'b0;
                lvl_chg <= 1'b1;
            end else if (trig) begin
                pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cwl_decode.sv
// Module: turns the level into data length, correction strength and parity size.
// Assumes each quantity doubles per level from its base value.
module cwl_decode
    import cwl_pkg::*;
#(
    parameter int unsigned BASE_DATA = 512,
    parameter int unsigned BASE_T    = 8,
    parameter int unsigned BASE_PAR  = 13,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CORR_W    = 10,
    parameter int unsigned PAR_W     = 10
) (
    input  lvl_t              level,
    output logic [DATA_W-1:0] data_bytes,
    output logic [CORR_W-1:0] corr_bits,
    output logic [PAR_W-1:0]  parity_bytes
);
    // Scale every base quantity by two to the power of the level.
    always_comb begin
        data_bytes   = DATA_W'(BASE_DATA) << level;
        corr_bits    = CORR_W'(BASE_T) << level;
        parity_bytes = PAR_W'(BASE_PAR) << level;
    end
endmodule

// File: rtl/cwlen_ctrl.sv
// Module: top of the wear-adaptive codeword length controller.
// Assumes erase_done and err_valid are single-cycle qualifiers and cw_idle
// marks cycles where the datapath may switch codeword size.
module cwlen_ctrl
    import cwl_pkg::*;
#(
    parameter int unsigned CYC_W     = 20,
    parameter int unsigned ERR_W     = 10,
    parameter int unsigned ETHR_W    = 10,
    parameter int unsigned BASE_DATA = 512,
    parameter int unsigned BASE_T    = 8,
    parameter int unsigned BASE_PAR  = 13,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CORR_W    = 10,
    parameter int unsigned PAR_W     = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          erase_done,
    input  logic                          err_valid,
    input  logic [ERR_W-1:0]              err_count,
    input  logic                          cw_idle,
    input  logic [(NUM_LVL-1)*CYC_W-1:0]  cyc_thr,
    input  logic [(NUM_LVL-1)*ETHR_W-1:0] err_thr,
    output logic [LVL_W-1:0]              level,
    output logic [DATA_W-1:0]             data_bytes,
    output logic [CORR_W-1:0]             corr_bits,
    output logic [PAR_W-1:0]              parity_bytes,
    output logic                          lvl_chg
);
    logic [CYC_W-1:0] wear;
    logic             trig;
    lvl_t             lvl_q;

    cwl_wear_cnt #(.CYC_W(CYC_W)) u_wear (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (erase_done),
        .count (wear)
    );

    cwl_trig #(.CYC_W(CYC_W), .ERR_W(ERR_W), .ETHR_W(ETHR_W)) u_trig (
        .level     (lvl_q),
        .wear      (wear),
        .err_valid (err_valid),
        .err_count (err_count),
        .cyc_thr   (cyc_thr),
        .err_thr   (err_thr),
        .trig      (trig)
    );

    cwl_step u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .cw_idle (cw_idle),
        .level   (lvl_q),
        .lvl_chg (lvl_chg)
    );

    cwl_decode #(
        .BASE_DATA (BASE_DATA), .BASE_T (BASE_T), .BASE_PAR (BASE_PAR),
        .DATA_W (DATA_W), .CORR_W (CORR_W), .PAR_W (PAR_W)
    ) u_dec (
        .level        (lvl_q),
        .data_bytes   (data_bytes),
        .corr_bits    (corr_bits),
        .parity_bytes (parity_bytes)
    );

    assign level = lvl_q;
endmodule

// File: rtl/cwlen_ctrl_chk.sv
// Module: checker for cwlen_ctrl, attached with bind.
// Assumes the default widths of the top module.
module cwlen_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cw_idle,
    input logic [2:0]  level,
    input logic        lvl_chg,
    input logic [15:0] data_bytes,
    input logic [9:0]  parity_bytes
);
    // R3: level holds or rises by one
    a_r3_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + 3'd1));

    // R7: any level change is marked by the strobe
    a_r7_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> lvl_chg);

    // R7: the strobe appears only together with a one-level rise
    a_r7_strobe_means_step: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_chg |-> (level == $past(level) + 3'd1));

    // R6: a step is applied only after an idle boundary
    a_r6_idle_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_chg |-> $past(cw_idle));

    // R9: the level never passes the ceiling
    a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        level <= 3'd6);

    // R2: parity and data keep the fixed 13:512 ratio
    a_r2_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(parity_bytes) * 32'd512) == (32'(data_bytes) * 32'd13));
endmodule

bind cwlen_ctrl cwlen_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cw_idle      (cw_idle),
    .level        (level),
    .lvl_chg      (lvl_chg),
    .data_bytes   (data_bytes),
    .parity_bytes (parity_bytes)
);

// File: tb/test_cwlen_ctrl.sv
module test_cwlen_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         erase_done = 1'b0;
    logic         err_valid = 1'b0;
    logic [9:0]   err_count = '0;
    logic         cw_idle = 1'b0;
    logic [119:0] cyc_thr;
    logic [59:0]  err_thr;
    logic [2:0]   level;
    logic [15:0]  data_bytes;
    logic [9:0]   corr_bits;
    logic [9:0]   parity_bytes;
    logic         lvl_chg;

    int n_chk = 0;
    int n_bad = 0;
    int chg_seen = 0;
    int chg_wide = 0;
    logic chg_q = 1'b0;
    bit done = 1'b0;

    // Error stimulus walked with cw_idle high: report value, level expected after it.
    localparam int NV = 12;
    localparam logic [9:0] V_ERR [NV] = '{10'd3, 10'd4, 10'd7, 10'd8, 10'd15, 10'd16,
                                         10'd100, 10'd63, 10'd64, 10'd127, 10'd128, 10'd1023};
    localparam logic [2:0] V_LVL [NV] = '{3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3,
                                         3'd4, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6};

    cwlen_ctrl i_cwlen_ctrl (
        .clk (clk), .rst_n (rst_n), .erase_done (erase_done),
        .err_valid (err_valid), .err_count (err_count), .cw_idle (cw_idle),
        .cyc_thr (cyc_thr), .err_thr (err_thr), .level (level),
        .data_bytes (data_bytes), .corr_bits (corr_bits),
        .parity_bytes (parity_bytes), .lvl_chg (lvl_chg)
    );

    always #5 clk = ~clk;

    // Count strobes and strobes longer than one cycle.
    always @(posedge clk) begin
        if (rst_n) begin
            if (lvl_chg) chg_seen++;
            if (lvl_chg && chg_q) chg_wide++;
        end
        chg_q = lvl_chg;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; erase_done = 1'b0; err_valid = 1'b0; cw_idle = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic erase(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); erase_done = 1'b1;
            @(negedge clk); erase_done = 1'b0;
        end
    endtask

    task automatic idle_pulse();
        @(negedge clk); cw_idle = 1'b1;
        @(negedge clk); cw_idle = 1'b0;
    endtask

    task automatic chk_cfg(input string req);
        chk(data_bytes == 16'(512 << level), req, int'(data_bytes), 512 << level);
        chk(corr_bits == 10'(8 << level), req, int'(corr_bits), 8 << level);
        chk(parity_bytes == 10'(13 << level), req, int'(parity_bytes), 13 << level);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            cyc_thr[i*20 +: 20] = 20'((i + 1) * 10);
            err_thr[i*10 +: 10] = 10'd4;
        end
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(level == 3'd0, "R1 level", int'(level), 0);
        chk(data_bytes == 16'd512, "R1 data", int'(data_bytes), 512);
        chk(corr_bits == 10'd8, "R1 corr", int'(corr_bits), 8);
        chk(parity_bytes == 10'd13, "R1 parity", int'(parity_bytes), 13);
        chk(lvl_chg == 1'b0, "R1 strobe", int'(lvl_chg), 0);

        // R5 R8 R9 R2: error-report vector walk with boundary always open
        cw_idle = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); err_valid = 1'b1; err_count = V_ERR[i];
            @(negedge clk); err_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(level == V_LVL[i], "R5/R8/R9 level", int'(level), int'(V_LVL[i]));
            chk_cfg("R2 config");
        end
        chk(chg_seen == 6, "R7 strobe count", chg_seen, 6);
        chk(chg_wide == 0, "R7 strobe width", chg_wide, 0);
        erase(80);
        repeat (3) @(negedge clk);
        chk(level == 3'd6 && chg_seen == 6, "R9 wear at ceiling", chg_seen, 6);

        // R10: reset returns to level 0 and clears the wear count
        do_reset();
        @(negedge clk);
        chk(level == 3'd0, "R10 level", int'(level), 0);
        erase(5);
        do_reset();
        cw_idle = 1'b1;
        erase(9);
        repeat (4) @(negedge clk);
        chk(level == 3'd0, "R10 wear cleared", int'(level), 0);
        erase(1);
        repeat (4) @(negedge clk);
        chk(level == 3'd1, "R4 wear threshold", int'(level), 1);

        // R6 R7 R8 R4: wear past several thresholds, steps gated by idle pulses
        do_reset();
        erase(35);
        repeat (3) @(negedge clk);
        chk(level == 3'd0, "R6 held without idle", int'(level), 0);
        idle_pulse();
        chk(level == 3'd1, "R8 single step", int'(level), 1);
        chk(lvl_chg == 1'b1, "R7 strobe with new level", int'(lvl_chg), 1);
        @(negedge clk);
        chk(lvl_chg == 1'b0, "R7 strobe one cycle", int'(lvl_chg), 0);
        @(negedge clk);
        idle_pulse();
        chk(level == 3'd2, "R8 second step", int'(level), 2);
        repeat (2) @(negedge clk);
        idle_pulse();
        chk(level == 3'd3, "R8 third step", int'(level), 3);
        repeat (2) @(negedge clk);
        idle_pulse();
        chk(level == 3'd3, "R4 below level-3 threshold", int'(level), 3);

        // R11: report coinciding with the applied step is discarded
        do_reset();
        @(negedge clk); err_valid = 1'b1; err_count = 10'd4;
        @(negedge clk); err_valid = 1'b1; err_count = 10'd8; cw_idle = 1'b1;
        @(negedge clk); err_valid = 1'b0;
        chk(level == 3'd1, "R11 step taken", int'(level), 1);
        repeat (4) @(negedge clk);
        chk(level == 3'd1, "R11 coinciding report dropped", int'(level), 1);
        chk(chg_wide == 0, "R7 strobe width end", chg_wide, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule